// File: doc/BRIEF.md
# Next-Line Prefetch Request Arbiter

This block is the entry stage of a shared second-level cache pipeline. Each clock cycle it picks at most one request and sends it down the pipeline through a registered output. There are three sources, in fixed order. The first is a request replayed by the external memory interface once a miss fill has landed. The second is a request from one of several cores, selected by an upstream one-hot grant. The third is a prefetch that the block generates itself.

When a replayed miss passes through and no prefetch run is in progress, the block arms a run. The run covers the lines that follow the missed one: it holds a line-aligned pointer one line past the missed address and issues a fixed number of prefetches, each one line higher than the last. A prefetch goes out only in a cycle that neither a replay nor a core uses, and only when the next stage can accept it. While a run is in progress, new replayed misses go through as normal but do not restart or extend the run.

Top module: `l2_front_arbiter`

## Requirements
- R1: A cycle with `fill_valid` high issues the replayed request on the next clock edge whatever `down_ready` is: `out_valid`=1, `out_is_fill`=1, and `out_addr`/`out_kind` equal to the replayed request's fields.
- R2: With no replay, a one-hot `core_grant` and `down_ready` high, the granted core's address and kind go out on the next edge with `out_is_fill`=0 and `out_core_id` equal to the granted bit's index.
- R3: With no replay and `down_ready` low, nothing is issued on the next edge (`out_valid`=0), even when a core is granted or a prefetch run is pending.
- R4: A replay whose kind is not the prefetch code (2'b10) arms a run when none is in progress. The first prefetch address is the replay address plus LINE_BYTES (64 by default).
- R5: An issued prefetch has `out_kind`=2'b10, `out_is_fill`=0 and `out_core_id`=0, and carries the current prefetch pointer.
- R6: A run issues exactly BURST_LEN prefetches (4 by default) at consecutive lines in ascending order, then stops. A miss at 0x00200000 gives 0x00200040, 0x00200080, 0x002000C0, 0x00200100.
- R7: While a run is in progress, a new replay does not re-arm the run. A replay of kind 2'b10 never arms one.
- R8: A prefetch is issued only in a cycle with no replay and no granted core. A preempted run resumes at the same pointer, with no line skipped or repeated.
- R9: The pointer arithmetic wraps modulo 2^ADDR_W. From 0xFFFFFF80 the run is 0xFFFFFFC0, 0x00000000, 0x00000040, 0x00000080.
- R10: Synchronous reset clears `out_valid` and cancels any run, so no prefetch follows reset until a new trigger arrives.
- R11: `out_valid` is low after any cycle in which none of the three sources issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Replayed request from the memory interface is present |
| fill_addr | input | ADDR_W | Address of the replayed request |
| fill_kind | input | 2 | Kind of the replayed request (2'b10 = prefetch) |
| core_grant | input | N_CORES | One-hot grant from the core arbiter |
| core_addr | input | N_CORES*ADDR_W | Core addresses, core i in bits [i*ADDR_W +: ADDR_W] |
| core_kind | input | N_CORES*2 | Core request kinds, core i in bits [i*2 +: 2] |
| down_ready | input | 1 | Next stage can accept a core or prefetch request |
| out_valid | output | 1 | Registered request valid |
| out_addr | output | ADDR_W | Registered request address |
| out_kind | output | 2 | Registered request kind |
| out_is_fill | output | 1 | Request is a replayed fill |
| out_core_id | output | ID_W | Index of the issuing core, 0 otherwise |

## Verification
Some properties are checked on every cycle: the source order, the rule that core and prefetch traffic waits for `down_ready`, arming on a non-prefetch replay, the run counter staying within its bound, and a quiet output after a cycle in which nothing can issue. Other behaviour needs a sequence of many cycles, so only the bench scenarios show it. These are the exact order and count of the prefetch addresses in a run, resuming after preemption without losing a line, ignoring replays that arrive mid-run, wraparound at the top of the address space, and a run cancelled by reset.

// File: rtl/l2fa_pkg.sv
package l2fa_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD     = 2'b00,
    KIND_STORE    = 2'b01,
    KIND_PREFETCH = 2'b10,
    KIND_FLUSH    = 2'b11
  } req_kind_t;

  localparam logic [1:0] PREFETCH_CODE = 2'b10;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/l2fa_core_select.sv
module l2fa_core_select #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned ID_W   = l2fa_pkg::idx_width(N_CORES)
) (
  input  logic [N_CORES-1:0]        grant,
  input  logic [N_CORES*ADDR_W-1:0] addr_flat,
  input  logic [N_CORES*2-1:0]      kind_flat,
  output logic                      any,
  output logic [ADDR_W-1:0]         sel_addr,
  output logic [1:0]                sel_kind,
  output logic [ID_W-1:0]           sel_id
);

  logic [ADDR_W-1:0] addr_term [N_CORES];
  logic [1:0]        kind_term [N_CORES];
  logic [ID_W-1:0]   id_term   [N_CORES];

  for (genvar g = 0; g < N_CORES; g++) begin : g_term
    assign addr_term[g] = grant[g] ? addr_flat[g*ADDR_W +: ADDR_W] : '0;
    assign kind_term[g] = grant[g] ? kind_flat[g*2 +: 2] : 2'b00;
    assign id_term[g]   = grant[g] ? ID_W'(g) : '0;
  end

  always_comb begin
    sel_addr = '0;
    sel_kind = 2'b00;
    sel_id   = '0;
    for (int i = 0; i < N_CORES; i++) begin
      sel_addr = sel_addr | addr_term[i];
      sel_kind = sel_kind | kind_term[i];
      sel_id   = sel_id   | id_term[i];
    end
  end

  assign any = |grant;

endmodule

// File: rtl/l2fa_prefetch_seq.sv
module l2fa_prefetch_seq #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned BURST_LEN  = 4,
  localparam int unsigned CNT_W     = l2fa_pkg::idx_width(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_req,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              inject,
  output logic              active,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [CNT_W-1:0]  cnt
);

  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(LINE_BYTES);
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(BURST_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      pf_addr <= '0;
    end else if (arm_req && !active) begin
      active  <= 1'b1;
      cnt     <= '0;
      pf_addr <= arm_addr + STEP;
    end else if (inject && active) begin
      pf_addr <= pf_addr + STEP;
      cnt     <= cnt + 1'b1;
      if (cnt == LAST_IDX) begin
        active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/l2fa_issue_reg.sv
module l2fa_issue_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_fill,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_kind,
  input  logic              take_core,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [1:0]        core_kind,
  input  logic [ID_W-1:0]   core_id,
  input  logic              take_pf,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_kind,
  output logic              out_is_fill,
  output logic [ID_W-1:0]   out_core_id
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_kind    <= l2fa_pkg::KIND_LOAD;
      out_is_fill <= 1'b0;
      out_core_id <= '0;
    end else if (take_fill) begin
      out_valid   <= 1'b1;
      out_addr    <= fill_addr;
      out_kind    <= fill_kind;
      out_is_fill <= 1'b1;
      out_core_id <= '0;
    end else if (take_core) begin
      out_valid   <= 1'b1;
      out_addr    <= core_addr;
      out_kind    <= core_kind;
      out_is_fill <= 1'b0;
      out_core_id <= core_id;
    end else if (take_pf) begin
      out_valid   <= 1'b1;
      out_addr    <= pf_addr;
      out_kind    <= l2fa_pkg::PREFETCH_CODE;
      out_is_fill <= 1'b0;
      out_core_id <= '0;
    end else begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/l2_front_arbiter.sv
module l2_front_arbiter #(
  parameter int unsigned N_CORES    = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned BURST_LEN  = 4,
  localparam int unsigned ID_W      = l2fa_pkg::idx_width(N_CORES),
  localparam int unsigned CNT_W     = l2fa_pkg::idx_width(BURST_LEN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fill_valid,
  input  logic [ADDR_W-1:0]         fill_addr,
  input  logic [1:0]                fill_kind,
  input  logic [N_CORES-1:0]        core_grant,
  input  logic [N_CORES*ADDR_W-1:0] core_addr,
  input  logic [N_CORES*2-1:0]      core_kind,
  input  logic                      down_ready,
  output logic                      out_valid,
  output logic [ADDR_W-1:0]         out_addr,
  output logic [1:0]                out_kind,
  output logic                      out_is_fill,
  output logic [ID_W-1:0]           out_core_id
);

  logic              core_any;
  logic [ADDR_W-1:0] core_sel_addr;
  logic [1:0]        core_sel_kind;
  logic [ID_W-1:0]   core_sel_id;
  logic              pf_active;
  logic [ADDR_W-1:0] pf_addr;
  logic [CNT_W-1:0]  pf_cnt;
  logic              arm_req;
  logic              take_core;
  logic              take_pf;

  l2fa_core_select #(
    .N_CORES(N_CORES),
    .ADDR_W (ADDR_W)
  ) u_sel (
    .grant    (core_grant),
    .addr_flat(core_addr),
    .kind_flat(core_kind),
    .any      (core_any),
    .sel_addr (core_sel_addr),
    .sel_kind (core_sel_kind),
    .sel_id   (core_sel_id)
  );

  assign arm_req   = fill_valid && (fill_kind != l2fa_pkg::PREFETCH_CODE);
  assign take_core = !fill_valid && core_any && down_ready;
  assign take_pf   = !fill_valid && !core_any && down_ready && pf_active;

  l2fa_prefetch_seq #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .BURST_LEN (BURST_LEN)
  ) u_pf (
    .clk     (clk),
    .rst     (rst),
    .arm_req (arm_req),
    .arm_addr(fill_addr),
    .inject  (take_pf),
    .active  (pf_active),
    .pf_addr (pf_addr),
    .cnt     (pf_cnt)
  );

  l2fa_issue_reg #(
    .ADDR_W(ADDR_W),
    .ID_W  (ID_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .take_fill  (fill_valid),
    .fill_addr  (fill_addr),
    .fill_kind  (fill_kind),
    .take_core  (take_core),
    .core_addr  (core_sel_addr),
    .core_kind  (core_sel_kind),
    .core_id    (core_sel_id),
    .take_pf    (take_pf),
    .pf_addr    (pf_addr),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_kind   (out_kind),
    .out_is_fill(out_is_fill),
    .out_core_id(out_core_id)
  );

endmodule

// File: rtl/l2fa_checker.sv
module l2fa_checker #(
  parameter int unsigned N_CORES   = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned CNT_W    = l2fa_pkg::idx_width(BURST_LEN)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      fill_valid,
  input logic [ADDR_W-1:0]         fill_addr,
  input logic [1:0]                fill_kind,
  input logic [N_CORES-1:0]        core_grant,
  input logic [N_CORES*ADDR_W-1:0] core_addr,
  input logic                      down_ready,
  input logic                      out_valid,
  input logic [ADDR_W-1:0]         out_addr,
  input logic [1:0]                out_kind,
  input logic                      out_is_fill,
  input logic                      pf_active,
  input logic [CNT_W-1:0]          pf_cnt
);

  logic [ADDR_W-1:0] granted_addr;
  always_comb begin
    granted_addr = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (core_grant[i]) granted_addr = core_addr[i*ADDR_W +: ADDR_W];
    end
  end

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_grant));

  a_r1_fill_first: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> out_valid && out_is_fill &&
                   out_addr == $past(fill_addr) && out_kind == $past(fill_kind));

  a_r2_core_next: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid && |core_grant && down_ready) |=>
      out_valid && !out_is_fill && out_addr == $past(granted_addr));

  a_r3_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid && !down_ready) |=> !out_valid);

  a_r4_arm: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_kind != l2fa_pkg::PREFETCH_CODE && !pf_active) |=>
      pf_active && pf_cnt == '0);

  a_r5_pf_kind: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid && !(|core_grant) && down_ready && pf_active) |=>
      out_valid && !out_is_fill && out_kind == l2fa_pkg::PREFETCH_CODE);

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    pf_active |-> pf_cnt <= CNT_W'(BURST_LEN - 1));

  a_r7_pf_no_arm: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_kind == l2fa_pkg::PREFETCH_CODE && !pf_active) |=> !pf_active);

  a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid && !(down_ready && (|core_grant || pf_active))) |=> !out_valid);

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid && !pf_active);

endmodule

bind l2_front_arbiter l2fa_checker #(
  .N_CORES  (N_CORES),
  .ADDR_W   (ADDR_W),
  .BURST_LEN(BURST_LEN)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_valid (fill_valid),
  .fill_addr  (fill_addr),
  .fill_kind  (fill_kind),
  .core_grant (core_grant),
  .core_addr  (core_addr),
  .down_ready (down_ready),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .out_kind   (out_kind),
  .out_is_fill(out_is_fill),
  .pf_active  (pf_active),
  .pf_cnt     (pf_cnt)
);

// File: tb/test_l2_front_arbiter.sv
module test_l2_front_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NC   = 4;
  localparam int AW   = 32;
  localparam int LINE = 64;
  localparam int BL   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [1:0]    fill_kind = 2'b00;
  logic [NC-1:0] core_grant = '0;
  logic [NC*AW-1:0] core_addr;
  logic [NC*2-1:0]  core_kind;
  logic          down_ready = 1'b1;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_kind;
  logic          out_is_fill;
  logic [1:0]    out_core_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_front_arbiter #(
    .N_CORES(NC), .ADDR_W(AW), .LINE_BYTES(LINE), .BURST_LEN(BL)
  ) i_l2_front_arbiter (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_kind(fill_kind),
    .core_grant(core_grant), .core_addr(core_addr), .core_kind(core_kind),
    .down_ready(down_ready),
    .out_valid(out_valid), .out_addr(out_addr), .out_kind(out_kind),
    .out_is_fill(out_is_fill), .out_core_id(out_core_id)
  );

  typedef struct {
    bit          v;
    logic [31:0] a;
    logic [1:0]  k;
    bit          f;
    logic [1:0]  id;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench-side expectation of the prefetch run, from R4-R10
  bit          m_act = 0;
  int          m_cnt = 0;
  logic [31:0] m_ptr = '0;

  function automatic logic [31:0] caddr(int i);
    return 32'h1000_0000 + 32'(i) * 32'h100;
  endfunction

  function automatic logic [1:0] ckind(int i);
    return (i == 3) ? 2'b01 : 2'b00;
  endfunction

  initial begin
    for (int i = 0; i < NC; i++) begin
      core_addr[i*AW +: AW] = caddr(i);
      core_kind[i*2 +: 2]   = ckind(i);
    end
  end

  task automatic step(input bit r, input bit fv, input logic [31:0] fa,
                      input logic [1:0] fk, input logic [NC-1:0] g,
                      input bit rdy, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; fill_valid = fv; fill_addr = fa; fill_kind = fk;
    core_grant = g; down_ready = rdy;
    e.v = 0; e.a = '0; e.k = 2'b00; e.f = 0; e.id = 2'd0; e.tag = tag;
    if (r) begin
      m_act = 0; m_cnt = 0;
    end else if (fv) begin
      e.v = 1; e.a = fa; e.k = fk; e.f = 1;
      if (!m_act && fk != 2'b10) begin
        m_act = 1; m_cnt = 0; m_ptr = fa + 32'(LINE);
      end
    end else if (g != '0 && rdy) begin
      for (int i = 0; i < NC; i++) begin
        if (g[i]) begin
          e.v = 1; e.a = caddr(i); e.k = ckind(i); e.id = 2'(i);
        end
      end
    end else if (m_act && rdy) begin
      e.v = 1; e.a = m_ptr; e.k = 2'b10;
      m_ptr = m_ptr + 32'(LINE);
      m_cnt++;
      if (m_cnt == BL) m_act = 0;
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n, input bit rdy, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, 2'b00, '0, rdy, tag);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (out_valid !== e.v) begin
          fails++;
          $display("FAIL %s: out_valid=%0b expected %0b", e.tag, out_valid, e.v);
        end else if (e.v && (out_addr !== e.a || out_kind !== e.k ||
                             out_is_fill !== e.f || out_core_id !== e.id)) begin
          fails++;
          $display("FAIL %s: addr=%h kind=%0d fill=%0b id=%0d expected addr=%h kind=%0d fill=%0b id=%0d",
                   e.tag, out_addr, out_kind, out_is_fill, out_core_id,
                   e.a, e.k, e.f, e.id);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    step(1, 0, '0, 2'b00, '0, 1, "R10 reset");
    step(1, 0, '0, 2'b00, '0, 1, "R10 reset");
    // R11 idle
    idle(2, 1, "R11 idle");
    // R2 each core, R3 blocked without ready
    for (int i = 0; i < NC; i++) step(0, 0, '0, 2'b00, NC'(1) << i, 1, "R2 core issue");
    step(0, 0, '0, 2'b00, 4'b0010, 0, "R3 core waits ready");
    // R1 R4 R5 R6 basic run from 0x00200000
    step(0, 1, 32'h0020_0000, 2'b00, '0, 1, "R1 R4 replay arms");
    idle(5, 1, "R5 R6 run of four");
    // R7 prefetch-kind replay does not arm
    step(0, 1, 32'h0040_0000, 2'b10, '0, 1, "R7 prefetch replay");
    idle(2, 1, "R7 no run");
    // R1 replay while not ready still issues
    step(0, 1, 32'h0030_0000, 2'b01, '0, 0, "R1 replay ignores ready");
    // R8 core preempts, R3 stall, R7 mid-run replay ignored
    step(0, 0, '0, 2'b00, 4'b0100, 1, "R8 core preempts");
    idle(1, 1, "R8 prefetch resumes");
    step(0, 0, '0, 2'b00, '0, 0, "R3 prefetch waits ready");
    step(0, 1, 32'h0050_0000, 2'b00, '0, 1, "R7 replay mid-run");
    step(0, 0, '0, 2'b00, 4'b1000, 1, "R8 core preempts");
    idle(4, 1, "R8 R6 run finishes");
    // R9 wraparound
    step(0, 1, 32'hFFFF_FF80, 2'b00, '0, 1, "R9 replay near top");
    idle(5, 1, "R9 wrap");
    // R10 reset cancels run
    step(0, 1, 32'h0060_0000, 2'b00, '0, 1, "R10 arm before reset");
    idle(1, 1, "R10 first prefetch");
    step(1, 0, '0, 2'b00, '0, 1, "R10 reset mid-run");
    idle(3, 1, "R10 no prefetch after reset");
    // R4 new run arms after reset
    step(0, 1, 32'h0070_0000, 2'b00, '0, 1, "R4 arm after reset");
    idle(5, 1, "R6 R11 run then idle");
    @(posedge clk); #2;
    @(posedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule